// File: doc/BRIEF.md
# Run-Time Folded Logic Cluster

This block is a group of four small logic elements that reuse their own hardware over time. Each element has a four-input lookup table and two storage flip-flops. Every element holds up to sixteen configuration words. A context index shared by all four elements picks which word is live in a given cycle. A shared sequencer moves the context index forward after a programmable number of clock cycles (the folding level). It wraps back to context zero after a programmable number of stages. This lets one physical element compute a different function in each folding stage.

The flip-flops keep their contents across context changes unless the live configuration enables a write. A value computed in one stage can therefore be consumed in a later one. A flip-flop that is written loads either the lookup-table result or a direct primary input bit.

The host first raises `hold`, which parks the sequencer and clears the flip-flops. It then writes configuration words through the write port, sets the folding level and the stage count, and releases `hold` to start folding.

Top module: `mcle_cluster`

## Requirements
- R1: After a synchronous `rst`, `ctx_idx` is 0, every `ff_q` bit is 0, and every configuration word is cleared to zero, so `lut_y` and `res_y` read 0.
- R2: `lut_y[e]` equals bit `{i3,i2,i1,i0}` of the 16-bit truth table (configuration bits 15:0) in element e's word for the current context. The index bits are `lut_in[4e+3:4e]`, with `lut_in[4e]` as the least significant index bit.
- R3: On a clock edge where write-enable bit k (configuration bit 18+k) is 1, flip-flop k of element e (`ff_q[2e+k]`) loads `byp_in[2e+k]` if source bit k (configuration bit 16+k) is 1, and loads `lut_y[e]` if that source bit is 0.
- R4: A flip-flop whose write-enable bit is 0 in the live word keeps its value, including across context changes.
- R5: While running, the context index holds for exactly p = `fold_level`+1 cycles and then steps to the next context.
- R6: The context after index `stage_last` is 0, so the sequence uses `stage_last`+1 contexts.
- R7: With `fold_level` = 0, the context index changes on every clock cycle.
- R8: A configuration write (`cfg_we`) is accepted only while `hold` is 1. While running, a write has no effect on any output.
- R9: A cycle with `hold` = 1 returns the context index and the intra-stage cycle count to 0 and clears all flip-flops on that edge.
- R10: `res_y[e]` equals `ff_q[2e]` when the output-select bit (configuration bit 20) is 1, and equals `lut_y[e]` when it is 0.
- R11: All four elements use the same context index at the same time, each with its own configuration word for that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also clears configuration |
| hold | input | 1 | Parks sequencer, clears flip-flops, opens configuration writes |
| fold_level | input | 4 | Folding level minus one (p = value+1) |
| stage_last | input | 4 | Index of last context before wrap |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_elem | input | 2 | Element addressed by the write |
| cfg_ctx | input | 4 | Context addressed by the write |
| cfg_data | input | 21 | Configuration word: [20] out select, [19:18] write enables, [17:16] source selects, [15:0] truth table |
| lut_in | input | 16 | Lookup-table inputs, four per element |
| byp_in | input | 8 | Direct flip-flop data, two per element |
| ctx_idx | output | 4 | Current context index |
| lut_y | output | 4 | Combinational lookup-table result per element |
| ff_q | output | 8 | Flip-flop contents, two per element |
| res_y | output | 4 | Selected result per element |

## Verification
The folding function is tried with three settings: single-cycle folding over four contexts, three-cycle folding over all sixteen contexts, and sixteen-cycle folding over two contexts. These settings separate an off-by-one in the stage length from an off-by-one in the wrap point. Lookup-table inputs and bypass data come from a pseudo-random sequence. Each element gets a distinct configuration per context, mixing both source selects, all write-enable combinations and both output selects. This exposes a wrong field position, a missed hold or a context shared wrongly between elements. Writes made while running target the live context, so any leak shows up in the next cycles, and a mid-run hold shows whether the counters and flip-flops are cleared.

// File: rtl/mcle_pkg.sv
package mcle_pkg;

    localparam int NUM_ELEM  = 4;
    localparam int NUM_CTX   = 16;
    localparam int LUT_IN    = 4;
    localparam int NUM_FF    = 2;
    localparam int FOLD_MAX  = 16;

    localparam int ELEM_W    = $clog2(NUM_ELEM);
    localparam int CTX_W     = $clog2(NUM_CTX);
    localparam int FOLD_W    = $clog2(FOLD_MAX);
    localparam int TT_W      = 1 << LUT_IN;
    localparam int CFG_W     = TT_W + 2 * NUM_FF + 1;

    // Configuration word; field positions are decoded by the element.
    typedef struct packed {
        logic              out_sel;
        logic [NUM_FF-1:0] wr_en;
        logic [NUM_FF-1:0] src_byp;
        logic [TT_W-1:0]   truth;
    } lecfg_t;

    function automatic logic lut_eval(input logic [TT_W-1:0] tt,
                                      input logic [LUT_IN-1:0] idx);
        return tt[idx];
    endfunction

endpackage

// File: rtl/mcle_seq.sv
module mcle_seq
    import mcle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [FOLD_W-1:0] fold_level,
    input  logic [CTX_W-1:0]  stage_last,
    output logic [CTX_W-1:0]  ctx,
    output logic              tick
);
    logic [FOLD_W-1:0] cyc;

    assign tick = !hold && (cyc == fold_level);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cyc <= '0;
            ctx <= '0;
        end else if (tick) begin
            cyc <= '0;
            if (ctx == stage_last)
                ctx <= '0;
            else
                ctx <= ctx + 1'b1;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end
endmodule

// File: rtl/mcle_cfg_mem.sv
module mcle_cfg_mem
    import mcle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              wr_req,
    input  logic [ELEM_W-1:0] wr_elem,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  lecfg_t            wr_word,
    input  logic [CTX_W-1:0]  rd_ctx,
    output lecfg_t            rd_word [NUM_ELEM]
);
    lecfg_t store [NUM_ELEM][NUM_CTX];
    logic   wr_ok;

    assign wr_ok = wr_req && hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < NUM_ELEM; e++)
                for (int c = 0; c < NUM_CTX; c++)
                    store[e][c] <= '0;
        end else if (wr_ok) begin
            store[wr_elem][wr_ctx] <= wr_word;
        end
    end

    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_rd
        assign rd_word[g] = store[g][rd_ctx];
    end
endmodule

// File: rtl/mcle_elem.sv
module mcle_elem
    import mcle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  lecfg_t            cfg,
    input  logic [LUT_IN-1:0] din,
    input  logic [NUM_FF-1:0] byp,
    output logic              lut_o,
    output logic [NUM_FF-1:0] q,
    output logic              res_o
);
    logic [NUM_FF-1:0] nxt;

    assign lut_o = lut_eval(cfg.truth, din);
    assign res_o = cfg.out_sel ? q[0] : lut_o;

    for (genvar k = 0; k < NUM_FF; k++) begin : g_ff
        assign nxt[k] = cfg.src_byp[k] ? byp[k] : lut_o;

        always_ff @(posedge clk) begin
            if (rst || hold)
                q[k] <= 1'b0;
            else if (cfg.wr_en[k])
                q[k] <= nxt[k];
        end
    end
endmodule

// File: rtl/mcle_cluster.sv
module mcle_cluster
    import mcle_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hold,
    input  logic [FOLD_W-1:0]          fold_level,
    input  logic [CTX_W-1:0]           stage_last,
    input  logic                       cfg_we,
    input  logic [ELEM_W-1:0]          cfg_elem,
    input  logic [CTX_W-1:0]           cfg_ctx,
    input  logic [CFG_W-1:0]           cfg_data,
    input  logic [NUM_ELEM*LUT_IN-1:0] lut_in,
    input  logic [NUM_ELEM*NUM_FF-1:0] byp_in,
    output logic [CTX_W-1:0]           ctx_idx,
    output logic [NUM_ELEM-1:0]        lut_y,
    output logic [NUM_ELEM*NUM_FF-1:0] ff_q,
    output logic [NUM_ELEM-1:0]        res_y
);
    logic   stage_tick;
    lecfg_t live [NUM_ELEM];

    mcle_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .fold_level (fold_level),
        .stage_last (stage_last),
        .ctx        (ctx_idx),
        .tick       (stage_tick)
    );

    mcle_cfg_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .wr_req  (cfg_we),
        .wr_elem (cfg_elem),
        .wr_ctx  (cfg_ctx),
        .wr_word (lecfg_t'(cfg_data)),
        .rd_ctx  (ctx_idx),
        .rd_word (live)
    );

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_le
        mcle_elem u_le (
            .clk   (clk),
            .rst   (rst),
            .hold  (hold),
            .cfg   (live[e]),
            .din   (lut_in[e*LUT_IN +: LUT_IN]),
            .byp   (byp_in[e*NUM_FF +: NUM_FF]),
            .lut_o (lut_y[e]),
            .q     (ff_q[e*NUM_FF +: NUM_FF]),
            .res_o (res_y[e])
        );
    end
endmodule

// File: rtl/mcle_cluster_chk.sv
module mcle_cluster_chk
    import mcle_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       hold,
    input logic [FOLD_W-1:0]          fold_level,
    input logic [CTX_W-1:0]           stage_last,
    input logic [CTX_W-1:0]           ctx_idx,
    input logic [NUM_ELEM*NUM_FF-1:0] ff_q,
    input logic                       stage_tick
);
    logic [FOLD_W-1:0] run_cnt;
    logic              rst_q;

    always_ff @(posedge clk) begin
        if (rst || hold || stage_tick)
            run_cnt <= '0;
        else
            run_cnt <= run_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst) begin
            a_r1_reset_state: assert (ctx_idx == '0 && ff_q == '0)
                else $error("R1 reset state wrong");
        end
    end

    a_r5_stage_length: assert property (@(posedge clk) disable iff (rst || hold)
        stage_tick |-> run_cnt == fold_level);

    a_r5_ctx_held: assert property (@(posedge clk) disable iff (rst || hold)
        !stage_tick |=> $stable(ctx_idx));

    a_r5_ctx_step: assert property (@(posedge clk) disable iff (rst || hold)
        stage_tick && ctx_idx != stage_last |=> ctx_idx == $past(ctx_idx) + 1'b1);

    a_r6_wrap: assert property (@(posedge clk) disable iff (rst || hold)
        stage_tick && ctx_idx == stage_last |=> ctx_idx == '0);

    a_r9_hold_clear: assert property (@(posedge clk) disable iff (rst)
        hold |=> ctx_idx == '0 && ff_q == '0);
endmodule

bind mcle_cluster mcle_cluster_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .fold_level (fold_level),
    .stage_last (stage_last),
    .ctx_idx    (ctx_idx),
    .ff_q       (ff_q),
    .stage_tick (stage_tick)
);

// File: tb/test_mcle_cluster.sv
module test_mcle_cluster;
    import mcle_pkg::*;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       hold = 1'b1;
    logic [FOLD_W-1:0]          fold_level = '0;
    logic [CTX_W-1:0]           stage_last = '0;
    logic                       cfg_we = 1'b0;
    logic [ELEM_W-1:0]          cfg_elem = '0;
    logic [CTX_W-1:0]           cfg_ctx = '0;
    logic [CFG_W-1:0]           cfg_data = '0;
    logic [NUM_ELEM*LUT_IN-1:0] lut_in = '0;
    logic [NUM_ELEM*NUM_FF-1:0] byp_in = '0;
    logic [CTX_W-1:0]           ctx_idx;
    logic [NUM_ELEM-1:0]        lut_y;
    logic [NUM_ELEM*NUM_FF-1:0] ff_q;
    logic [NUM_ELEM-1:0]        res_y;

    always #2 clk = ~clk;

    mcle_cluster i_mcle_cluster (.*);

    typedef struct packed {
        logic [CTX_W-1:0]           ctx;
        logic [NUM_ELEM-1:0]        lut;
        logic [NUM_ELEM*NUM_FF-1:0] ff;
        logic [NUM_ELEM-1:0]        res;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    event  item_ev;
    int    n_run = 0;
    int    n_fail = 0;

    // Bench-side reference state built from the requirements.
    logic [CFG_W-1:0]           mcfg [NUM_ELEM][NUM_CTX];
    logic [CTX_W-1:0]           mctx = '0;
    logic [FOLD_W-1:0]          mcyc = '0;
    logic [NUM_ELEM*NUM_FF-1:0] mff = '0;
    logic [15:0]                lfsr = 16'hACE1;

    function automatic logic [CFG_W-1:0] make_word(int e, int c);
        logic [15:0] tt;
        logic [1:0]  src, wen;
        logic        osel;
        tt   = (16'h6996 ^ (16'h1111 * c[15:0])) + (16'h0F1E * e[15:0]);
        src  = 2'((c + e) % 4);
        wen  = 2'((c * 3 + e) % 4);
        osel = c[0] ^ e[0];
        return {osel, wen, src, tt};
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops each expected item and compares before the next edge.
    initial begin
        forever begin
            @(item_ev);
            #1;
            while (exp_q.size() > 0) begin
                exp_t  x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " R5/R6/R7/R9/R11"}, "ctx_idx", int'(ctx_idx), int'(x.ctx));
                check({t, " R2/R11"}, "lut_y", int'(lut_y), int'(x.lut));
                check({t, " R3/R4/R9"}, "ff_q", int'(ff_q), int'(x.ff));
                check({t, " R10"}, "res_y", int'(res_y), int'(x.res));
            end
        end
    end

    // Driver: one cycle of stimulus, pushes expected outputs, advances model.
    task automatic cycle(input logic h, input logic we, input int we_e,
                         input int we_c, input logic [CFG_W-1:0] wd, input string tag);
        exp_t x;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        @(negedge clk);
        hold     = h;
        cfg_we   = we;
        cfg_elem = ELEM_W'(we_e);
        cfg_ctx  = CTX_W'(we_c);
        cfg_data = wd;
        lut_in   = lfsr;
        byp_in   = lfsr[7:0] ^ lfsr[15:8];
        x.ctx = mctx;
        for (int e = 0; e < NUM_ELEM; e++) begin
            lecfg_t w;
            w = lecfg_t'(mcfg[e][mctx]);
            x.lut[e] = w.truth[lut_in[e*LUT_IN +: LUT_IN]];
            x.res[e] = w.out_sel ? mff[e*NUM_FF] : x.lut[e];
        end
        x.ff = mff;
        exp_q.push_back(x);
        tag_q.push_back(tag);
        ->item_ev;
        if (h) begin
            if (we) mcfg[we_e][we_c] = wd;
            mctx = '0;
            mcyc = '0;
            mff  = '0;
        end else begin
            for (int e = 0; e < NUM_ELEM; e++) begin
                lecfg_t w;
                w = lecfg_t'(mcfg[e][mctx]);
                for (int k = 0; k < NUM_FF; k++)
                    if (w.wr_en[k])
                        mff[e*NUM_FF + k] = w.src_byp[k] ? byp_in[e*NUM_FF + k] : x.lut[e];
            end
            if (mcyc == fold_level) begin
                mcyc = '0;
                mctx = (mctx == stage_last) ? '0 : mctx + 1'b1;
            end else begin
                mcyc = mcyc + 1'b1;
            end
        end
    endtask

    task automatic load_all();
        for (int e = 0; e < NUM_ELEM; e++)
            for (int c = 0; c < NUM_CTX; c++)
                cycle(1'b1, 1'b1, e, c, make_word(e, c), "load");
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++)
            cycle(1'b0, 1'b0, 0, 0, '0, tag);
    endtask

    task automatic finish_up();
        @(negedge clk);
        #1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int e = 0; e < NUM_ELEM; e++)
            for (int c = 0; c < NUM_CTX; c++)
                mcfg[e][c] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset, configuration empty
        cycle(1'b1, 1'b0, 0, 0, '0, "R1");
        load_all();

        // R7: one cycle per stage, four contexts (R6 wrap at 3)
        fold_level = 4'd0;
        stage_last = 4'd3;
        run(24, "R7");

        // R9: hold mid-run clears counters and flip-flops
        cycle(1'b1, 1'b0, 0, 0, '0, "R9");
        // R5: three cycles per stage over all sixteen contexts
        fold_level = 4'd2;
        stage_last = 4'd15;
        run(60, "R5");
        cycle(1'b1, 1'b0, 0, 0, '0, "R9");

        // R6: sixteen cycles per stage, wrap after two contexts
        fold_level = 4'd15;
        stage_last = 4'd1;
        run(40, "R6");

        // R8: writes while running aimed at the live context must be ignored
        for (int i = 0; i < 20; i++)
            cycle(1'b0, 1'b1, i % NUM_ELEM, int'(mctx), {CFG_W{1'b1}}, "R8");
        run(20, "R8");
        cycle(1'b1, 1'b0, 0, 0, '0, "R9");
        fold_level = 4'd0;
        stage_last = 4'd15;
        run(20, "R8");

        finish_up();
    end
endmodule